// File: doc/BRIEF.md
# ROM To Memory Loader

This block copies a program image of a fixed number of 32-bit words from a synchronous-read ROM into memory. It is the bus master on an AXI4-Lite write channel set. A one-cycle start pulse carries a base byte address. The block then walks the ROM word index from zero upwards. For each word it waits one cycle for the ROM output, issues one write of that word with all byte lanes enabled, and waits for the write response before it moves on.

When the last word has been acknowledged, the block raises a finished flag and issues no more writes. The flag stays high until another start pulse arrives, which runs the whole copy again from word zero, possibly to a different base. Only the write channels are present, because the loader never reads through the bus.

Top module: `rom_image_loader`

## Requirements
- R1: After reset the finished flag is low, no write channel valid or response ready is high, and the ROM word address is 0.
- R2: The base address is taken only in the cycle where the start input is high; later changes of the base input have no effect on the copy in progress.
- R3: Word i goes to byte address base + 4*i; every write carries strobe 4'b1111 and protection 3'b000.
- R4: The data of the write for word i equals ROM entry i, where the ROM presents entry a one clock after address a is applied.
- R5: The ROM word address starts at 0, only ever steps by +1 or returns to 0, and holds steady from the first cycle of a word's write until that write's response is accepted.
- R6: Exactly one address handshake and one data handshake occur per word, and both valids are low in the cycle after a write response is accepted.
- R7: No new write is requested while a response is outstanding, and response ready is high only while a response is awaited.
- R8: Address valid and data valid each stay high until their own ready is seen, and the address does not change while address valid waits.
- R9: After the response to the last word the finished flag goes high and stays high, and no further writes occur until a new start.
- R10: A start pulse while finished clears the flag on the next cycle and copies again from word 0 to the new base.
- R11: A start pulse while a copy is running has no effect on that copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin a copy |
| loadBase | input | 32 | Byte address of word 0, taken with startPulse |
| romAddr | output | IW | ROM word index (IW = clog2 of WORDS) |
| romData | input | 32 | ROM output, one cycle after romAddr |
| loadDone | output | 1 | High once the whole image is written |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awAddr | output | 32 | Write byte address |
| awProt | output | 3 | Protection attributes, always 0 |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wData | output | 32 | Write data |
| wStrb | output | 4 | Byte strobes, always all ones |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready |

## Verification
The slave model accepts address and data on independent, pseudo-randomly stalled cycles and delays its response. A loader that waited for only one of the two handshakes, or moved on before the response, would reach the next word early and break the expected order of addresses. Every ROM word holds a distinct value, so a loader that ignored the one-cycle ROM latency would write the previous word's data. The bench also changes the base input just after the pulse and fires a stray start mid-copy; a design that kept sampling the base or restarted would write to the wrong addresses. After each finish it watches for stray writes, then restarts to a new base to catch a stale index or a stuck flag.

// File: rtl/romld_pkg.sv
package romld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WRITE,
    ST_RESP,
    ST_NEXT,
    ST_DONE
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;  // capture base, clear word index
    logic incIdx;     // step to the next word
  } ldStrobe_t;

endpackage

// File: rtl/romld_datapath.sv
module romld_datapath
  import romld_pkg::*;
#(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ldStrobe_t     strobe,
  input  logic [31:0]   loadBase,
  output logic [IW-1:0] wordIdx,
  output logic          lastWord,
  output logic [31:0]   byteAddr
);

  localparam logic [IW-1:0] LastIdx = IW'(WORDS - 1);

  logic [31:0] baseReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      wordIdx <= '0;
    end else if (strobe.loadStart) begin
      baseReg <= loadBase;
      wordIdx <= '0;
    end else if (strobe.incIdx) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  assign lastWord = (wordIdx == LastIdx);
  assign byteAddr = baseReg + {{(30 - IW){1'b0}}, wordIdx, 2'b00};

endmodule

// File: rtl/romld_ctrl.sv
module romld_ctrl
  import romld_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      lastWord,
  input  logic      awReady,
  input  logic      wReady,
  input  logic      bValid,
  output ldStrobe_t strobe,
  output logic      awValid,
  output logic      wValid,
  output logic      bReady,
  output logic      loadDone
);

  ldState_t state, stateNext;
  logic awSent, wSent;
  logic awFin, wFin;

  always_comb begin
    awValid  = (state == ST_WRITE) && !awSent;
    wValid   = (state == ST_WRITE) && !wSent;
    bReady   = (state == ST_RESP);
    loadDone = (state == ST_DONE);
    awFin    = awSent || (awValid && awReady);
    wFin     = wSent || (wValid && wReady);

    strobe.loadStart = startPulse && ((state == ST_IDLE) || (state == ST_DONE));
    strobe.incIdx    = (state == ST_NEXT) && !lastWord;

    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE: if (startPulse) stateNext = ST_FETCH;
      ST_FETCH:         stateNext = ST_WRITE;
      ST_WRITE:         if (awFin && wFin) stateNext = ST_RESP;
      ST_RESP:          if (bValid) stateNext = ST_NEXT;
      ST_NEXT:          stateNext = lastWord ? ST_DONE : ST_FETCH;
      default:          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      awSent <= 1'b0;
      wSent  <= 1'b0;
    end else begin
      state <= stateNext;
      if ((state == ST_WRITE) && !(awFin && wFin)) begin
        awSent <= awFin;
        wSent  <= wFin;
      end else begin
        awSent <= 1'b0;
        wSent  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rom_image_loader.sv
module rom_image_loader
  import romld_pkg::*;
#(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic [31:0]   loadBase,
  output logic [IW-1:0] romAddr,
  input  logic [31:0]   romData,
  output logic          loadDone,
  output logic          awValid,
  input  logic          awReady,
  output logic [31:0]   awAddr,
  output logic [2:0]    awProt,
  output logic          wValid,
  input  logic          wReady,
  output logic [31:0]   wData,
  output logic [3:0]    wStrb,
  input  logic          bValid,
  output logic          bReady
);

  ldStrobe_t strobe;
  logic      lastWord;

  romld_ctrl ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lastWord(lastWord),
    .awReady(awReady), .wReady(wReady), .bValid(bValid), .strobe(strobe),
    .awValid(awValid), .wValid(wValid), .bReady(bReady), .loadDone(loadDone)
  );

  romld_datapath #(.WORDS(WORDS)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadBase(loadBase),
    .wordIdx(romAddr), .lastWord(lastWord), .byteAddr(awAddr)
  );

  // ROM address is frozen through the write, so its output is used directly
  assign wData  = romData;
  assign wStrb  = 4'b1111;
  assign awProt = 3'b000;

endmodule

// File: rtl/romld_checker.sv
module romld_checker #(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rstN,
  input logic [IW-1:0] romAddr,
  input logic          loadDone,
  input logic          awValid,
  input logic          awReady,
  input logic [31:0]   awAddr,
  input logic          wValid,
  input logic          wReady,
  input logic [3:0]    wStrb,
  input logic          bReady
);

  a_r3_full_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> wStrb == 4'b1111);

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> awAddr[1:0] == 2'b00);

  a_r8_aw_hold: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> (awValid && $stable(awAddr)));

  a_r8_w_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && !wReady) |=> wValid);

  a_r5_rom_steady: assert property (@(posedge clk) disable iff (!rstN)
    (awValid || wValid || bReady) |=> $stable(romAddr));

  a_r5_rom_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(romAddr) |-> ((romAddr == $past(romAddr) + 1'b1) || (romAddr == '0)));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (!awValid && !wValid && !bReady));

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    bReady |-> (!awValid && !wValid));

endmodule

bind rom_image_loader romld_checker #(.WORDS(WORDS)) chk (
  .clk(clk), .rstN(rstN), .romAddr(romAddr), .loadDone(loadDone),
  .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
  .wValid(wValid), .wReady(wReady), .wStrb(wStrb), .bReady(bReady)
);

// File: tb/rom_image_loader_test.sv
module rom_image_loader_test;

  localparam int WORDS = 16;
  localparam int IW = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [31:0]   loadBase = '0;
  logic [IW-1:0] romAddr;
  logic [31:0]   romData = '0;
  logic          loadDone;
  logic          awValid, wValid, bReady;
  logic          awReady = 1'b0, wReady = 1'b0, bValid = 1'b0;
  logic [31:0]   awAddr, wData;
  logic [2:0]    awProt;
  logic [3:0]    wStrb;

  int total = 0;
  int bad = 0;

  logic [31:0] rom [WORDS];
  logic [31:0] expAddr [$];
  logic [31:0] expData [$];
  int          expIdx [$];

  int   stallMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rom_image_loader #(.WORDS(WORDS)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .loadBase(loadBase),
    .romAddr(romAddr), .romData(romData), .loadDone(loadDone),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awProt(awProt),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb),
    .bValid(bValid), .bReady(bReady)
  );

  // synchronous ROM: entry appears one clock after its address
  always @(posedge clk) romData <= rom[romAddr];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  bit awGot = 0, wGot = 0, pendB = 0, justResp = 0;
  int bWait = 0;
  logic [31:0] capAddr, capData;

  always @(negedge clk) begin
    if (rstN) begin
      // effects of the edge that just passed
      justResp = pendB;
      if (pendB) begin
        bValid = 1'b0;
        awGot = 0;
        wGot = 0;
      end else if (awGot && wGot && !bValid) begin
        if (bWait > 0) bWait--;
        else bValid = 1'b1;
      end
      // readiness for the coming edge
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (stallMode == 0) begin
        awReady = 1'b1;
        wReady  = 1'b1;
      end else begin
        awReady = lfsr[0];
        wReady  = lfsr[5];
      end
      // handshakes on the coming edge
      if (justResp) begin
        check(!awValid && !wValid, "R6 valids low after response", {30'd0, awValid, wValid}, 32'd0);
      end
      if (awValid && awGot && wGot)
        check(1'b0, "R7 request while response outstanding", 32'd1, 32'd0);
      pendB = bValid && bReady;
      if (bReady && !(awGot && wGot))
        check(1'b0, "R7 response ready with nothing outstanding", 32'd1, 32'd0);
      if (awValid && awReady) begin
        if (awGot) check(1'b0, "R6 second address handshake", awAddr, capAddr);
        awGot = 1;
        capAddr = awAddr;
        check(awProt == 3'b000, "R3 protection", {29'd0, awProt}, 32'd0);
      end
      if (wValid && wReady) begin
        if (wGot) check(1'b0, "R6 second data handshake", wData, capData);
        wGot = 1;
        capData = wData;
        check(wStrb == 4'hF, "R3 strobe", {28'd0, wStrb}, 32'hF);
      end
      if (awGot && wGot && !bValid && bWait == 0 && !pendB && !justResp
          && ((awValid && awReady) || (wValid && wReady))) begin
        if (expAddr.size() == 0) begin
          check(1'b0, "R9 write with no copy expected", capAddr, 32'd0);
        end else begin
          check(capAddr == expAddr[0], "R3 write address", capAddr, expAddr[0]);
          check(capData == expData[0], "R4 write data", capData, expData[0]);
          check(int'(romAddr) == expIdx[0], "R5 rom address during write", 32'(romAddr), 32'(expIdx[0]));
          void'(expAddr.pop_front());
          void'(expData.pop_front());
          void'(expIdx.pop_front());
        end
        bWait = (stallMode == 0) ? 0 : int'(lfsr[2:1]);
      end
    end
  end

  task automatic pulseStart(input logic [31:0] base);
    @(negedge clk);
    startPulse = 1'b1;
    loadBase = base;
    @(negedge clk);
    startPulse = 1'b0;
    loadBase = ~base ^ 32'h0F0F_0000; // R2: later base values must be ignored
  endtask

  task automatic startLoad(input logic [31:0] base);
    for (int i = 0; i < WORDS; i++) begin
      expAddr.push_back(base + 32'(4 * i));
      expData.push_back(rom[i]);
      expIdx.push_back(i);
    end
    pulseStart(base);
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!loadDone && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(loadDone, req, {31'd0, loadDone}, 32'd1);
    check(expAddr.size() == 0, "R6 all words written once", 32'(expAddr.size()), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) rom[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h1234_5678;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!loadDone, "R1 finished low", {31'd0, loadDone}, 32'd0);
    check(!awValid && !wValid && !bReady, "R1 bus idle", {29'd0, awValid, wValid, bReady}, 32'd0);
    check(romAddr == '0, "R1 rom address", 32'(romAddr), 32'd0);

    // R3 R4 R5: free-running slave
    stallMode = 0;
    startLoad(32'h0000_1000);
    waitDone("R9 finished after first copy");

    // R9: flag held, no stray writes
    repeat (12) @(negedge clk);
    check(loadDone, "R9 finished stays high", {31'd0, loadDone}, 32'd1);

    // R10 R8: restart with new base, stalled slave
    stallMode = 1;
    startLoad(32'h8000_0200);
    check(!loadDone, "R10 finished cleared by start", {31'd0, loadDone}, 32'd0);
    check(romAddr == '0, "R10 restart at word 0", 32'(romAddr), 32'd0);
    waitDone("R10 finished after restart");

    // R11: stray start in mid-copy
    startLoad(32'h0004_0000);
    begin
      int n = 0;
      while (romAddr != IW'(3) && n < 2000) begin
        @(negedge clk);
        n++;
      end
    end
    pulseStart(32'hBAD0_0000);
    waitDone("R11 copy unaffected by stray start");
    repeat (12) @(negedge clk);
    check(loadDone, "R9 finished stays high after stalled copy", {31'd0, loadDone}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule